// File: doc/BRIEF.md
# ECAM Configuration Request Router

This block sits behind a host register port at the root of a PCI Express hierarchy. It turns memory-mapped configuration accesses into configuration transactions. The host presents a byte address, write data and byte enables. The block splits the address into bus, device, function and register offset. It then compares the bus number against three bus registers that it holds itself: primary, secondary and subordinate.

From that comparison each access takes one of four paths. It is served from the root port's own small configuration space. It becomes a Type 0 request descriptor for the device directly below. It becomes a Type 1 request descriptor for buses further down. Or it is refused with an unsupported-request status. Only one forwarded access is in flight at a time. The access ends when a downstream completion returns or when a programmable timeout expires.

Top module: `ecam_cfg_router`

## Requirements
- R1: The address is decoded as bus = addr[27:20], device = addr[19:15], function = addr[14:12], byte offset = addr[11:0]. A forwarded descriptor carries these fields, the dword register number addr[11:2], the host byte enables and the write data, and its write flag equals the host write flag.
- R2: An access whose bus equals the primary bus, with device 0 and function 0, is served locally. It creates no descriptor, and its response (`rsp_valid`) appears on the clock edge that accepts it.
- R3: Local reads return fixed words. Offset 0x000 returns the ID word (0x0A5C1B7E). Offset 0x100 returns the AER header (0x1C010001). Offset 0x1C0 returns the secondary PCIe header (0x1F010019). Offset 0x1F0 returns the VC header (0x00010002). Any other offset except 0x018 reads 0. Local writes to these read-only offsets have no effect.
- R4: Local offset 0x018 holds the bus registers: primary in bits [7:0], secondary in [15:8], subordinate in [23:16], with bits [31:24] reading 0. Each byte is written only when its byte enable is set. All three reset to 0.
- R5: A bus equal to the secondary bus (and not the primary bus) with device 0 produces a Type 0 descriptor (`dsc_type1` = 0).
- R6: A bus greater than the secondary bus and no greater than the subordinate bus produces a Type 1 descriptor (`dsc_type1` = 1).
- R7: Any other access is not forwarded. This covers a bus outside these ranges, the primary bus with a nonzero device or function, and the secondary bus with a nonzero device. The response status is 1 (unsupported). A read returns 0xFFFFFFFF and a write returns 0.
- R8: While `dsc_valid` is high and `dsc_ready` is low, the descriptor fields stay stable.
- R9: From the accept of a forwarded access until its response, `host_ready` stays low.
- R10: A completion with `cpl_err` low ends the access with status 0. A read then returns `cpl_data` and a write returns 0. With `cpl_err` high the status is 1 and a read returns 0xFFFFFFFF.
- R11: If no completion has arrived, the response comes `tmo_limit`+1 clock edges after the accepting edge, with status 2 and data 0xFFFFFFFF for a read, and `dsc_valid` drops. A completion on the same edge as the expiry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tmo_limit | input | 16 | Timeout limit in cycles |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Access accepted this cycle when high with host_valid |
| host_we | input | 1 | 1 = write |
| host_addr | input | 28 | ECAM byte address |
| host_be | input | 4 | Byte enables |
| host_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 32 | Read data |
| rsp_status | output | 2 | 0 ok, 1 unsupported, 2 timeout |
| dsc_valid | output | 1 | Descriptor valid |
| dsc_ready | input | 1 | Descriptor taken |
| dsc_type1 | output | 1 | 1 = Type 1, 0 = Type 0 |
| dsc_write | output | 1 | 1 = write request |
| dsc_bus | output | 8 | Target bus |
| dsc_dev | output | 5 | Target device |
| dsc_fn | output | 3 | Target function |
| dsc_reg | output | 10 | Dword register number |
| dsc_be | output | 4 | First-dword byte enables |
| dsc_wdata | output | 32 | Write data |
| cpl_valid | input | 1 | Completion arrives |
| cpl_err | input | 1 | Completion reports an error |
| cpl_data | input | 32 | Completion read data |

## Verification
A downstream completion and the expiry of the timeout can land on the same clock edge. The bench provokes this with a limit of 5: it hands off the descriptor at once and then raises `cpl_valid` exactly on the edge where the counter reaches the limit. The response must then carry status 0 and the completion data, not the timeout pattern. A second run without any completion checks that the timeout response arrives on precisely edge `tmo_limit`+1 and no earlier.

// File: rtl/ecam_cfg_router.sv
module ecam_cfg_router #(
  parameter int          TMO_W   = 16,
  parameter logic [31:0] ID_WORD = 32'h0A5C_1B7E,
  parameter logic [31:0] AER_HDR = 32'h1C01_0001,
  parameter logic [31:0] SPE_HDR = 32'h1F01_0019,
  parameter logic [31:0] VC_HDR  = 32'h0001_0002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic             host_we,
  input  logic [27:0]      host_addr,
  input  logic [3:0]       host_be,
  input  logic [31:0]      host_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data,
  output logic [1:0]       rsp_status,
  output logic             dsc_valid,
  input  logic             dsc_ready,
  output logic             dsc_type1,
  output logic             dsc_write,
  output logic [7:0]       dsc_bus,
  output logic [4:0]       dsc_dev,
  output logic [2:0]       dsc_fn,
  output logic [9:0]       dsc_reg,
  output logic [3:0]       dsc_be,
  output logic [31:0]      dsc_wdata,
  input  logic             cpl_valid,
  input  logic             cpl_err,
  input  logic [31:0]      cpl_data
);
  localparam logic [1:0] ST_OK = 2'd0, ST_UR = 2'd1, ST_TMO = 2'd2;
  localparam logic [9:0] RG_ID = 10'h000, RG_BUS = 10'h006,
                         RG_AER = 10'h040, RG_SPE = 10'h070, RG_VC = 10'h07C;

  typedef enum logic [1:0] {IDLE, SEND, WAIT} st_t;
  typedef enum logic [1:0] {GO_LOCAL, GO_T0, GO_T1, GO_UR} route_t;

  st_t             st;
  route_t          route;
  logic [7:0]      pri, sec, sub;
  logic [TMO_W-1:0] cnt;
  logic            rd_q;
  logic [31:0]     local_rd;

  wire [7:0] a_bus = host_addr[27:20];
  wire [4:0] a_dev = host_addr[19:15];
  wire [2:0] a_fn  = host_addr[14:12];
  wire [9:0] a_reg = host_addr[11:2];
  wire       accept = host_valid && host_ready;
  wire       expire = (cnt == tmo_limit);

  assign host_ready = (st == IDLE);

  always_comb begin
    if (a_bus == pri)
      route = (a_dev == 5'd0 && a_fn == 3'd0) ? GO_LOCAL : GO_UR;
    else if (a_bus == sec)
      route = (a_dev == 5'd0) ? GO_T0 : GO_UR;
    else if (a_bus > sec && a_bus <= sub)
      route = GO_T1;
    else
      route = GO_UR;
  end

  always_comb begin
    case (a_reg)
      RG_ID:   local_rd = ID_WORD;
      RG_BUS:  local_rd = {8'h00, sub, sec, pri};
      RG_AER:  local_rd = AER_HDR;
      RG_SPE:  local_rd = SPE_HDR;
      RG_VC:   local_rd = VC_HDR;
      default: local_rd = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      pri <= 8'h0; sec <= 8'h0; sub <= 8'h0;
      cnt <= '0;
      rd_q <= 1'b0;
      rsp_valid <= 1'b0; rsp_data <= 32'h0; rsp_status <= ST_OK;
      dsc_valid <= 1'b0; dsc_type1 <= 1'b0; dsc_write <= 1'b0;
      dsc_bus <= 8'h0; dsc_dev <= 5'h0; dsc_fn <= 3'h0; dsc_reg <= 10'h0;
      dsc_be <= 4'h0; dsc_wdata <= 32'h0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        IDLE: if (accept) begin
          rd_q <= !host_we;
          cnt  <= '0;
          case (route)
            GO_LOCAL: begin
              rsp_valid  <= 1'b1;
              rsp_status <= ST_OK;
              rsp_data   <= host_we ? 32'h0 : local_rd;
              if (host_we && a_reg == RG_BUS) begin
                if (host_be[0]) pri <= host_wdata[7:0];
                if (host_be[1]) sec <= host_wdata[15:8];
                if (host_be[2]) sub <= host_wdata[23:16];
              end
            end
            GO_UR: begin
              rsp_valid  <= 1'b1;
              rsp_status <= ST_UR;
              rsp_data   <= host_we ? 32'h0 : 32'hFFFF_FFFF;
            end
            default: begin
              st        <= SEND;
              dsc_valid <= 1'b1;
              dsc_type1 <= (route == GO_T1);
              dsc_write <= host_we;
              dsc_bus   <= a_bus;
              dsc_dev   <= a_dev;
              dsc_fn    <= a_fn;
              dsc_reg   <= a_reg;
              dsc_be    <= host_be;
              dsc_wdata <= host_wdata;
            end
          endcase
        end
        SEND, WAIT: begin
          if (st == WAIT && cpl_valid) begin
            st         <= IDLE;
            rsp_valid  <= 1'b1;
            rsp_status <= cpl_err ? ST_UR : ST_OK;
            rsp_data   <= !rd_q ? 32'h0 : (cpl_err ? 32'hFFFF_FFFF : cpl_data);
          end else if (expire) begin
            st         <= IDLE;
            dsc_valid  <= 1'b0;
            rsp_valid  <= 1'b1;
            rsp_status <= ST_TMO;
            rsp_data   <= rd_q ? 32'hFFFF_FFFF : 32'h0;
          end else begin
            cnt <= cnt + 1'b1;
            if (st == SEND && dsc_ready) begin
              dsc_valid <= 1'b0;
              st        <= WAIT;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  p_local_nodsc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && route == GO_LOCAL) |=> (rsp_valid && !dsc_valid));

  p_ur_nodsc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && route == GO_UR) |=> (rsp_valid && rsp_status == ST_UR && !dsc_valid));

  p_dsc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_valid && !dsc_ready) |=> (!dsc_valid ||
      $stable({dsc_type1, dsc_write, dsc_bus, dsc_dev, dsc_fn, dsc_reg, dsc_be, dsc_wdata})));

  p_one_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid |-> !host_ready);

  p_tmo_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_TMO) |-> (!dsc_valid && $past(st) != IDLE));
endmodule

// File: tb/ecam_cfg_router_tb_top.sv
module ecam_cfg_router_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic [15:0] tmo_limit = 16'd50;
  logic host_valid = 0, host_we = 0, dsc_ready = 0, cpl_valid = 0, cpl_err = 0;
  logic [27:0] host_addr = '0;
  logic [3:0]  host_be = '0;
  logic [31:0] host_wdata = '0, cpl_data = '0;
  logic host_ready, rsp_valid, dsc_valid, dsc_type1, dsc_write;
  logic [31:0] rsp_data, dsc_wdata;
  logic [1:0]  rsp_status;
  logic [7:0]  dsc_bus;
  logic [4:0]  dsc_dev;
  logic [2:0]  dsc_fn;
  logic [9:0]  dsc_reg;
  logic [3:0]  dsc_be;

  ecam_cfg_router dut_i (.*);

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  localparam logic [1:0] K_LOC = 0, K_T0 = 1, K_T1 = 2, K_UR = 3;
  // {we, addr, be, wdata, kind, expected data}
  localparam logic [98:0] VEC [15] = '{
    {1'b0, 28'h0000018, 4'hF, 32'h0, K_LOC, 32'h0004_0100},
    {1'b0, 28'h0000000, 4'hF, 32'h0, K_LOC, 32'h0A5C_1B7E},
    {1'b0, 28'h0000100, 4'hF, 32'h0, K_LOC, 32'h1C01_0001},
    {1'b0, 28'h00001C0, 4'hF, 32'h0, K_LOC, 32'h1F01_0019},
    {1'b0, 28'h00001F0, 4'hF, 32'h0, K_LOC, 32'h0001_0002},
    {1'b0, 28'h0000104, 4'hF, 32'h0, K_LOC, 32'h0},
    {1'b0, 28'h0102040, 4'hF, 32'h0, K_T0, 32'hC010_2040},
    {1'b1, 28'h0100010, 4'h3, 32'hDEAD_BEEF, K_T0, 32'h0},
    {1'b0, 28'h0329010, 4'h6, 32'h0, K_T1, 32'hC032_9010},
    {1'b0, 28'h04FFFFC, 4'hF, 32'h0, K_T1, 32'hC04F_FFFC},
    {1'b0, 28'h0500000, 4'hF, 32'h0, K_UR, 32'hFFFF_FFFF},
    {1'b0, 28'h0118000, 4'hF, 32'h0, K_UR, 32'hFFFF_FFFF},
    {1'b0, 28'h0008000, 4'hF, 32'h0, K_UR, 32'hFFFF_FFFF},
    {1'b1, 28'h0900000, 4'hF, 32'h1234, K_UR, 32'h0},
    {1'b0, 28'h0001000, 4'hF, 32'h0, K_UR, 32'hFFFF_FFFF}
  };

  // Drive one access; returns after the accepting edge, at the following negedge.
  task automatic issue(input bit we, input logic [27:0] a, input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1; host_we = we; host_addr = a; host_be = be; host_wdata = wd;
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic local_access(input bit we, input logic [27:0] a, input logic [3:0] be,
                              input logic [31:0] wd, output logic [31:0] d);
    issue(we, a, be, wd);
    d = rsp_data;
    chk(rsp_valid && rsp_status == 2'd0, "R2 local response", {30'h0, rsp_status}, 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk(host_ready && !rsp_valid && !dsc_valid, "R9 reset idle", {29'h0, host_ready, rsp_valid, dsc_valid}, 32'h4);
    rst_n = 1;
    local_access(1, 28'h0000018, 4'hF, 32'h0000_0000, d);
    local_access(0, 28'h0000018, 4'hF, 32'h0, d);
    chk(d == 32'h0, "R4 bus regs reset", d, 32'h0);
    local_access(1, 28'h0000018, 4'h7, 32'hFF04_0100, d);

    foreach (VEC[i]) begin
      logic        we;
      logic [27:0] a;
      logic [3:0]  be;
      logic [31:0] wd, ex;
      logic [1:0]  k;
      {we, a, be, wd, k, ex} = VEC[i];
      issue(we, a, be, wd);
      if (k == K_LOC || k == K_UR) begin
        chk(rsp_valid && !dsc_valid, k == K_LOC ? "R2 served locally" : "R7 not forwarded",
            {30'h0, rsp_valid, dsc_valid}, 32'h2);
        chk(rsp_status == (k == K_UR ? 2'd1 : 2'd0), "R7 status", {30'h0, rsp_status}, {31'h0, k == K_UR});
        chk(rsp_data == ex, k == K_LOC ? "R3 local data" : "R7 refused data", rsp_data, ex);
      end else begin
        chk(dsc_valid && dsc_type1 == (k == K_T1), k == K_T1 ? "R6 type1" : "R5 type0",
            {31'h0, dsc_type1}, {31'h0, k == K_T1});
        chk(dsc_bus == a[27:20] && dsc_dev == a[19:15] && dsc_fn == a[14:12] && dsc_reg == a[11:2]
            && dsc_be == be && dsc_write == we && dsc_wdata == wd, "R1 descriptor fields",
            {dsc_bus, dsc_dev, dsc_fn, dsc_reg, 6'h0}, {a[27:12], a[11:2], 6'h0});
        chk(!host_ready, "R9 stalled", {31'h0, host_ready}, 32'h0);
        dsc_ready = 1;
        @(negedge clk);
        dsc_ready = 0;
        cpl_valid = 1; cpl_err = 0; cpl_data = {4'hC, a};
        @(negedge clk);
        cpl_valid = 0;
        chk(rsp_valid && rsp_status == 2'd0 && rsp_data == ex, "R10 completion", rsp_data, ex);
      end
    end

    // R3: write to read-only stub is ignored
    local_access(1, 28'h0000100, 4'hF, 32'h0, d);
    local_access(0, 28'h0000100, 4'hF, 32'h0, d);
    chk(d == 32'h1C01_0001, "R3 stub unchanged", d, 32'h1C01_0001);

    // R4: byte-enable limited write changes only secondary
    local_access(1, 28'h0000018, 4'h2, 32'h7777_0277, d);
    local_access(0, 28'h0000018, 4'hF, 32'h0, d);
    chk(d == 32'h0004_0200, "R4 byte enable", d, 32'h0004_0200);
    issue(0, 28'h0100000, 4'hF, 32'h0);
    chk(rsp_valid && rsp_status == 2'd1 && !dsc_valid, "R7 old secondary now refused", rsp_data, 32'hFFFF_FFFF);
    local_access(1, 28'h0000018, 4'h2, 32'h0000_0100, d);

    // R8: descriptor held while not ready
    issue(1, 28'h0208008, 4'h5, 32'hA5A5_5A5A);
    repeat (3) @(negedge clk);
    chk(dsc_valid && dsc_bus == 8'h02 && dsc_reg == 10'h002 && dsc_wdata == 32'hA5A5_5A5A && dsc_type1,
        "R8 hold", dsc_wdata, 32'hA5A5_5A5A);
    dsc_ready = 1; @(negedge clk); dsc_ready = 0;
    cpl_valid = 1; cpl_err = 1; @(negedge clk); cpl_valid = 0; cpl_err = 0;
    chk(rsp_valid && rsp_status == 2'd1 && rsp_data == 32'h0, "R10 write error", rsp_data, 32'h0);

    // R10: error completion on a read
    issue(0, 28'h0100000, 4'hF, 32'h0);
    dsc_ready = 1; @(negedge clk); dsc_ready = 0;
    cpl_valid = 1; cpl_err = 1; cpl_data = 32'h1; @(negedge clk); cpl_valid = 0; cpl_err = 0;
    chk(rsp_valid && rsp_status == 2'd1 && rsp_data == 32'hFFFF_FFFF, "R10 read error", rsp_data, 32'hFFFF_FFFF);

    // R11: timeout on exact edge, descriptor never taken
    tmo_limit = 16'd5;
    begin
      int n = 0;
      issue(0, 28'h0300000, 4'hF, 32'h0);
      while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
      chk(n == 6, "R11 timeout edge", n, 6);
      chk(rsp_status == 2'd2 && rsp_data == 32'hFFFF_FFFF && !dsc_valid && host_ready,
          "R11 timeout response", rsp_data, 32'hFFFF_FFFF);
    end

    // R11: completion on the expiry edge wins
    issue(0, 28'h0100000, 4'hF, 32'h0);
    dsc_ready = 1; @(negedge clk); dsc_ready = 0;
    repeat (4) @(negedge clk);
    chk(!rsp_valid, "R11 no early response", {31'h0, rsp_valid}, 32'h0);
    cpl_valid = 1; cpl_data = 32'h600D_F00D;
    @(negedge clk);
    cpl_valid = 0;
    chk(rsp_valid && rsp_status == 2'd0 && rsp_data == 32'h600D_F00D, "R11 tie completion wins",
        rsp_data, 32'h600D_F00D);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule